// File: doc/BRIEF.md
# Context-Tagged Set-Associative Translation Cache

This block caches virtual-to-physical page translations for a processor's memory pipeline. It holds 128 entries arranged as 32 sets of 4 ways. Each entry stores a page tag, a 13-bit address-space context, a global flag, a physical page number and a small group of property bits. A lookup supplies a virtual page number and the current context. One cycle later the block answers with hit or miss, plus the physical page and properties on a hit. Because entries carry a context, translations from many address spaces can stay resident together. Entries flagged global are shared by every context.

A single command port maintains the contents. It can load an entry, drop every entry for one virtual page, drop the private entries of one context, or clear the whole cache. Loads place the new entry in a free way if the set has one. Otherwise they evict the least recently used way. Walking page tables and handling misses belong to the surrounding logic.

The lookup request is a valid/ready stream. `lk_ready` is low in any cycle where `cmd_valid` is high, so a command always wins that cycle. The requester must then hold `lk_valid` and its fields stable until it sees ready. The response cannot be stalled: `rsp_valid` pulses for exactly one cycle per accepted lookup. Commands are plain control and are always taken in the cycle they are presented.

Top module: `tlb_ctx_cache`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is low and `lk_ready` is high; a lookup of any page then misses.
- R2: The set is chosen by the low 5 bits of the 20-bit virtual page number, and the upper 15 bits are kept as the tag. Pages that share a set but differ in the tag never alias.
- R3: A lookup hits only on a valid entry with an equal tag whose stored context equals `lk_ctx` or whose global flag is set.
- R4: A lookup accepted on a clock edge produces `rsp_valid` high for exactly the following cycle. `rsp_valid` is low in all other cycles. On a miss, `rsp_ppn` and `rsp_prop` are zero.
- R5: A fill into a set with no matching entry writes the lowest-numbered invalid way, and leaves every valid entry of the set resident.
- R6: A fill into a full set with no matching entry evicts the way least recently hit or filled. Every lookup hit and every fill marks its way as most recent.
- R7: A fill whose tag matches a valid entry of the same ownership overwrites that entry in place. Same ownership means both are global, or both are private with equal context.
- R8: `cmd_op` = 1 (page invalidate) clears every entry whose tag and set match `cmd_vpn`, whatever its context or global flag.
- R9: `cmd_op` = 2 (context flush) clears the non-global entries whose context equals `cmd_ctx`. Global entries and entries of other contexts stay valid.
- R10: `cmd_op` = 3 (flush all) clears every entry, so any lookup accepted afterwards misses.
- R11: While `cmd_valid` is high, `lk_ready` is low and no lookup is accepted. A lookup held across the command is accepted later and sees the command's effect.
- R12: `cmd_op` = 0 (fill) stores `cmd_ppn` and `cmd_prop`. A hit returns exactly these values for the matching entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high with lk_valid |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_ctx | input | 13 | Context of the requesting address space |
| rsp_valid | output | 1 | Lookup result valid, one cycle after acceptance |
| rsp_hit | output | 1 | Result is a hit |
| rsp_ppn | output | 20 | Physical page number on a hit, zero on a miss |
| rsp_prop | output | 4 | Property bits on a hit, zero on a miss |
| cmd_valid | input | 1 | Maintenance command present this cycle |
| cmd_op | input | 2 | 0 fill, 1 page invalidate, 2 context flush, 3 flush all |
| cmd_vpn | input | 20 | Page for fill or invalidate |
| cmd_ctx | input | 13 | Context for fill or context flush |
| cmd_global | input | 1 | Global flag for a fill |
| cmd_ppn | input | 20 | Physical page for a fill |
| cmd_prop | input | 4 | Property bits for a fill |

## Verification
Two of this block's functions can compete for one cycle: a lookup and a maintenance command, because both read the arrays and both may update the recency state. The bench raises a fill and a lookup on the very same cycle for a page not yet present. It checks that `lk_ready` is low in that cycle and that no response appears the next cycle. It then checks that the held lookup, once accepted, hits with the values just loaded. The recency order is judged separately by sequences in one set, where the only visible effect is which tag survives an eviction.

// File: rtl/tlb_ctx_pkg.sv
package tlb_ctx_pkg;

  typedef enum logic [1:0] {
    OP_FILL      = 2'd0,
    OP_INV_PAGE  = 2'd1,
    OP_FLUSH_CTX = 2'd2,
    OP_FLUSH_ALL = 2'd3
  } tlb_op_e;

  // Match rule used by one comparator bank
  typedef enum int {
    MATCH_LOOKUP = 0,  // tag, and context equal or global
    MATCH_OWNER  = 1,  // tag, and same ownership (for in-place refill)
    MATCH_PAGE   = 2   // tag only (page invalidate)
  } match_mode_e;

endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_ctx_pkg::*;
#(
  parameter int          WAYS  = 4,
  parameter int          TAG_W = 15,
  parameter int          CTX_W = 13,
  parameter match_mode_e MODE  = MATCH_LOOKUP
) (
  input  logic [WAYS-1:0]            ent_valid,
  input  logic [WAYS-1:0]            ent_glob,
  input  logic [WAYS-1:0][TAG_W-1:0] ent_tag,
  input  logic [WAYS-1:0][CTX_W-1:0] ent_ctx,
  input  logic [TAG_W-1:0]           key_tag,
  input  logic [CTX_W-1:0]           key_ctx,
  input  logic                       key_glob,
  output logic [WAYS-1:0]            hit
);

  logic [WAYS-1:0] tag_eq;
  logic [WAYS-1:0] ctx_eq;

  // Some modes ignore part of the key; fold it into a sink.
  logic unused_key;
  assign unused_key = ^{key_ctx, key_glob, ent_ctx, ent_glob};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign tag_eq[w] = ent_valid[w] && (ent_tag[w] == key_tag);
    assign ctx_eq[w] = (ent_ctx[w] == key_ctx);

    if (MODE == MATCH_LOOKUP) begin : g_lookup
      assign hit[w] = tag_eq[w] && (ent_glob[w] || ctx_eq[w]);
    end else if (MODE == MATCH_OWNER) begin : g_owner
      assign hit[w] = tag_eq[w] &&
                      (ent_glob[w] ? key_glob : (!key_glob && ctx_eq[w]));
    end else begin : g_page
      assign hit[w] = tag_eq[w];
    end
  end

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int SETS = 32,
  parameter int WAYS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     touch_en,
  input  logic [$clog2(SETS)-1:0]  touch_set,
  input  logic [$clog2(WAYS)-1:0]  touch_way,
  input  logic [$clog2(SETS)-1:0]  q_set,
  output logic [$clog2(WAYS)-1:0]  victim_way
);

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  // Per set, the ages form a permutation of 0..WAYS-1; 0 is most recent.
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] touched_age;

  assign touched_age = age_q[touch_set][touch_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way) begin
          age_q[touch_set][w] <= '0;
        end else if (age_q[touch_set][w] < touched_age) begin
          age_q[touch_set][w] <= age_q[touch_set][w] + WAY_W'(1);
        end
      end
    end
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[q_set][w] == OLDEST) victim_way = WAY_W'(w);
    end
  end

  logic [SET_W-1:0] unused_set_w;
  assign unused_set_w = '0;

endmodule

// File: rtl/tlb_ctx_cache.sv
module tlb_ctx_cache
  import tlb_ctx_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int CTX_W  = 13,
  parameter int PROP_W = 4,
  parameter int SETS   = 32,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [CTX_W-1:0]  lk_ctx,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [PROP_W-1:0] rsp_prop,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [VPN_W-1:0]  cmd_vpn,
  input  logic [CTX_W-1:0]  cmd_ctx,
  input  logic              cmd_global,
  input  logic [PPN_W-1:0]  cmd_ppn,
  input  logic [PROP_W-1:0] cmd_prop
);

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = VPN_W - SET_W;

  // ---------------- entry storage ----------------
  logic [WAYS-1:0]             v_q    [SETS];
  logic [WAYS-1:0]             glob_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q  [SETS];
  logic [WAYS-1:0][CTX_W-1:0]  ctx_q  [SETS];
  logic [WAYS-1:0][PPN_W-1:0]  ppn_q  [SETS];
  logic [WAYS-1:0][PROP_W-1:0] prop_q [SETS];

  function automatic logic [WAY_W-1:0] lowest_way(input logic [WAYS-1:0] vec);
    lowest_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vec[w]) lowest_way = WAY_W'(w);
    end
  endfunction

  // ---------------- lookup path ----------------
  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  lk_hits;
  logic             lk_any;
  logic [WAY_W-1:0] lk_way;
  logic             lk_fire;

  assign lk_set   = lk_vpn[SET_W-1:0];
  assign lk_tag   = lk_vpn[VPN_W-1:SET_W];
  assign lk_ready = !cmd_valid;
  assign lk_fire  = lk_valid && lk_ready;

  tlb_match #(
    .WAYS(WAYS), .TAG_W(TAG_W), .CTX_W(CTX_W), .MODE(MATCH_LOOKUP)
  ) u_lk_match (
    .ent_valid (v_q[lk_set]),
    .ent_glob  (glob_q[lk_set]),
    .ent_tag   (tag_q[lk_set]),
    .ent_ctx   (ctx_q[lk_set]),
    .key_tag   (lk_tag),
    .key_ctx   (lk_ctx),
    .key_glob  (1'b0),
    .hit       (lk_hits)
  );

  assign lk_any = |lk_hits;
  assign lk_way = lowest_way(lk_hits);

  // ---------------- command path ----------------
  tlb_op_e          op;
  logic [SET_W-1:0] cmd_set;
  logic [TAG_W-1:0] cmd_tag;
  logic [WAYS-1:0]  own_hits;
  logic [WAYS-1:0]  page_hits;
  logic [WAYS-1:0]  free_ways;
  logic [WAY_W-1:0] lru_way;
  logic [WAY_W-1:0] fill_way;
  logic             do_fill;

  assign op      = tlb_op_e'(cmd_op);
  assign cmd_set = cmd_vpn[SET_W-1:0];
  assign cmd_tag = cmd_vpn[VPN_W-1:SET_W];
  assign do_fill = cmd_valid && (op == OP_FILL);

  tlb_match #(
    .WAYS(WAYS), .TAG_W(TAG_W), .CTX_W(CTX_W), .MODE(MATCH_OWNER)
  ) u_own_match (
    .ent_valid (v_q[cmd_set]),
    .ent_glob  (glob_q[cmd_set]),
    .ent_tag   (tag_q[cmd_set]),
    .ent_ctx   (ctx_q[cmd_set]),
    .key_tag   (cmd_tag),
    .key_ctx   (cmd_ctx),
    .key_glob  (cmd_global),
    .hit       (own_hits)
  );

  tlb_match #(
    .WAYS(WAYS), .TAG_W(TAG_W), .CTX_W(CTX_W), .MODE(MATCH_PAGE)
  ) u_page_match (
    .ent_valid (v_q[cmd_set]),
    .ent_glob  (glob_q[cmd_set]),
    .ent_tag   (tag_q[cmd_set]),
    .ent_ctx   (ctx_q[cmd_set]),
    .key_tag   (cmd_tag),
    .key_ctx   (cmd_ctx),
    .key_glob  (cmd_global),
    .hit       (page_hits)
  );

  assign free_ways = ~v_q[cmd_set];

  always_comb begin
    if (|own_hits)       fill_way = lowest_way(own_hits);
    else if (|free_ways) fill_way = lowest_way(free_ways);
    else                 fill_way = lru_way;
  end

  // ---------------- recency state ----------------
  logic             touch_en;
  logic [SET_W-1:0] touch_set;
  logic [WAY_W-1:0] touch_way;

  // A command and an accepted lookup never share a cycle.
  assign touch_en  = do_fill || (lk_fire && lk_any);
  assign touch_set = do_fill ? cmd_set  : lk_set;
  assign touch_way = do_fill ? fill_way : lk_way;

  tlb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (touch_en),
    .touch_set  (touch_set),
    .touch_way  (touch_way),
    .q_set      (cmd_set),
    .victim_way (lru_way)
  );

  // ---------------- valid bits ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) v_q[s] <= '0;
    end else if (cmd_valid) begin
      unique case (op)
        OP_FILL:     v_q[cmd_set][fill_way] <= 1'b1;
        OP_INV_PAGE: v_q[cmd_set] <= v_q[cmd_set] & ~page_hits;
        OP_FLUSH_CTX: begin
          for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
              if (!glob_q[s][w] && (ctx_q[s][w] == cmd_ctx)) v_q[s][w] <= 1'b0;
            end
          end
        end
        OP_FLUSH_ALL: begin
          for (int s = 0; s < SETS; s++) v_q[s] <= '0;
        end
        default: ;
      endcase
    end
  end

  // ---------------- entry payload ----------------
  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[cmd_set][fill_way]  <= cmd_tag;
      ctx_q[cmd_set][fill_way]  <= cmd_ctx;
      glob_q[cmd_set][fill_way] <= cmd_global;
      ppn_q[cmd_set][fill_way]  <= cmd_ppn;
      prop_q[cmd_set][fill_way] <= cmd_prop;
    end
  end

  // ---------------- response register ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
      rsp_prop  <= '0;
    end else begin
      rsp_valid <= lk_fire;
      rsp_hit   <= lk_fire && lk_any;
      if (lk_fire) begin
        rsp_ppn  <= lk_any ? ppn_q[lk_set][lk_way]  : '0;
        rsp_prop <= lk_any ? prop_q[lk_set][lk_way] : '0;
      end
    end
  end

endmodule

// File: rtl/tlb_ctx_cache_chk.sv
module tlb_ctx_cache_chk #(
  parameter int PPN_W  = 20,
  parameter int PROP_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [PPN_W-1:0]  rsp_ppn,
  input logic [PROP_W-1:0] rsp_prop
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rsp_valid);

  assert_rsp_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);

  assert_rsp_only_on_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_ready) |=> !rsp_valid);

  assert_hit_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_hit);

  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && rsp_prop == '0));

  assert_flush_all_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(cmd_valid && cmd_op == 2'd3, 2)) |-> !rsp_hit);

  assert_cmd_stalls_lookup_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !lk_ready);

endmodule

bind tlb_ctx_cache tlb_ctx_cache_chk #(.PPN_W(PPN_W), .PROP_W(PROP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_ready  (lk_ready),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_ppn   (rsp_ppn),
  .rsp_prop  (rsp_prop)
);

// File: tb/sim_tlb_ctx_cache.sv
`timescale 1ns/1ps
module sim_tlb_ctx_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [19:0] lk_vpn = '0;
  logic [12:0] lk_ctx = '0;
  logic        rsp_valid, rsp_hit;
  logic [19:0] rsp_ppn;
  logic [3:0]  rsp_prop;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [19:0] cmd_vpn = '0;
  logic [12:0] cmd_ctx = '0;
  logic        cmd_global = 1'b0;
  logic [19:0] cmd_ppn = '0;
  logic [3:0]  cmd_prop = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  tlb_ctx_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vpn(lk_vpn), .lk_ctx(lk_ctx),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_prop(rsp_prop),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_vpn(cmd_vpn), .cmd_ctx(cmd_ctx),
    .cmd_global(cmd_global), .cmd_ppn(cmd_ppn), .cmd_prop(cmd_prop)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // op: 0 fill, 1 page invalidate, 2 context flush, 3 flush all
  task automatic do_cmd(input logic [1:0] op, input logic [19:0] vpn,
                        input logic [12:0] ctx, input logic glob,
                        input logic [19:0] ppn);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_vpn = vpn; cmd_ctx = ctx;
    cmd_global = glob; cmd_ppn = ppn; cmd_prop = ppn[3:0];
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_lookup(input logic [19:0] vpn, input logic [12:0] ctx,
                           input logic exp_hit, input logic [19:0] exp_ppn,
                           input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = vpn; lk_ctx = ctx;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rsp_valid == 1'b1, {req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk(rsp_hit == exp_hit, {req, " hit"}, 32'(rsp_hit), 32'(exp_hit));
    if (exp_hit) begin
      chk(rsp_ppn == exp_ppn && rsp_prop == exp_ppn[3:0], {req, " ppn/prop"},
          {8'h0, rsp_prop, rsp_ppn}, {8'h0, exp_ppn[3:0], exp_ppn});
    end else begin
      chk(rsp_ppn == '0 && rsp_prop == '0, {req, " miss zero (R4)"},
          {8'h0, rsp_prop, rsp_ppn}, 32'h0);
    end
  endtask

  // Vector: [57:55] kind (0..3 command op, 4 lookup), [54:35] vpn,
  // [34:22] ctx, [21] global, [20:1] ppn / expected ppn, [0] expected hit
  localparam int NV = 18;
  localparam logic [57:0] VEC [NV] = '{
    {3'd0, 20'h00123, 13'd5,  1'b0, 20'hAAAA1, 1'b0},
    {3'd4, 20'h00123, 13'd5,  1'b0, 20'hAAAA1, 1'b1},  // R3, R12
    {3'd4, 20'h00123, 13'd6,  1'b0, 20'h00000, 1'b0},  // R3 other context
    {3'd0, 20'h00456, 13'd9,  1'b1, 20'hBBBB2, 1'b0},
    {3'd4, 20'h00456, 13'd77, 1'b0, 20'hBBBB2, 1'b1},  // R3 global
    {3'd0, 20'h00321, 13'd8,  1'b0, 20'hEEEE5, 1'b0},
    {3'd4, 20'h00143, 13'd5,  1'b0, 20'h00000, 1'b0},  // R2 same set, new tag
    {3'd2, 20'h00000, 13'd5,  1'b0, 20'h00000, 1'b0},
    {3'd4, 20'h00123, 13'd5,  1'b0, 20'h00000, 1'b0},  // R9 flushed
    {3'd4, 20'h00456, 13'd5,  1'b0, 20'hBBBB2, 1'b1},  // R9 global kept
    {3'd4, 20'h00321, 13'd8,  1'b0, 20'hEEEE5, 1'b1},  // R9 other context kept
    {3'd0, 20'h00789, 13'd3,  1'b0, 20'hCCCC3, 1'b0},
    {3'd0, 20'h00789, 13'd4,  1'b0, 20'hDDDD4, 1'b0},
    {3'd1, 20'h00789, 13'd0,  1'b0, 20'h00000, 1'b0},
    {3'd4, 20'h00789, 13'd3,  1'b0, 20'h00000, 1'b0},  // R8
    {3'd4, 20'h00789, 13'd4,  1'b0, 20'h00000, 1'b0},  // R8 any context
    {3'd3, 20'h00000, 13'd0,  1'b0, 20'h00000, 1'b0},
    {3'd4, 20'h00456, 13'd1,  1'b0, 20'h00000, 1'b0}   // R10
  };

  function automatic logic [19:0] s7(input int tag);
    return {15'(tag), 5'd7};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && lk_ready == 1'b1, "R1 idle after reset",
        {30'd0, rsp_valid, lk_ready}, 32'd1);
    do_lookup(20'h00000, 13'd0, 1'b0, 20'h0, "R1 empty lookup");
    do_lookup(20'hFFFFF, 13'd8191, 1'b0, 20'h0, "R1 empty lookup high");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][57:55] == 3'd4)
        do_lookup(VEC[i][54:35], VEC[i][34:22], VEC[i][0], VEC[i][20:1],
                  $sformatf("R3/R12 table step %0d", i));
      else
        do_cmd(VEC[i][56:55], VEC[i][54:35], VEC[i][34:22], VEC[i][21], VEC[i][20:1]);
    end

    // R2: same set, different tags, plus neighbouring set
    do_cmd(2'd0, {15'h1, 5'd3}, 13'd1, 1'b0, 20'h11111);
    do_cmd(2'd0, {15'h2, 5'd3}, 13'd1, 1'b0, 20'h22222);
    do_cmd(2'd0, {15'h1, 5'd4}, 13'd1, 1'b0, 20'h33333);
    do_lookup({15'h1, 5'd3}, 13'd1, 1'b1, 20'h11111, "R2 tag1 set3");
    do_lookup({15'h2, 5'd3}, 13'd1, 1'b1, 20'h22222, "R2 tag2 set3");
    do_lookup({15'h1, 5'd4}, 13'd1, 1'b1, 20'h33333, "R2 tag1 set4");

    // R6: fill set 7 with tags 1..4, touch order 1,2,3,4 then 1 again
    do_cmd(2'd3, 20'h0, 13'd0, 1'b0, 20'h0);
    for (int t = 1; t <= 4; t++) do_cmd(2'd0, s7(t), 13'd1, 1'b0, 20'h01000 + 20'(t));
    for (int t = 1; t <= 4; t++) do_lookup(s7(t), 13'd1, 1'b1, 20'h01000 + 20'(t), "R6 resident");
    do_lookup(s7(1), 13'd1, 1'b1, 20'h01001, "R6 retouch");
    do_cmd(2'd0, s7(5), 13'd1, 1'b0, 20'h01005);  // evicts tag 2
    do_lookup(s7(2), 13'd1, 1'b0, 20'h0, "R6 oldest evicted");
    do_lookup(s7(1), 13'd1, 1'b1, 20'h01001, "R6 survivor");
    do_lookup(s7(3), 13'd1, 1'b1, 20'h01003, "R6 survivor");
    do_lookup(s7(4), 13'd1, 1'b1, 20'h01004, "R6 survivor");
    do_lookup(s7(5), 13'd1, 1'b1, 20'h01005, "R6 new entry");
    // Oldest now tag 1. R5: free a way, fill must use it, not evict tag 1.
    do_cmd(2'd1, s7(4), 13'd0, 1'b0, 20'h0);
    do_cmd(2'd0, s7(6), 13'd1, 1'b0, 20'h01006);
    do_lookup(s7(4), 13'd1, 1'b0, 20'h0, "R5 invalidated");
    do_lookup(s7(3), 13'd1, 1'b1, 20'h01003, "R5 kept");
    do_lookup(s7(1), 13'd1, 1'b1, 20'h01001, "R5 oldest kept");
    do_lookup(s7(5), 13'd1, 1'b1, 20'h01005, "R5 kept");
    do_lookup(s7(6), 13'd1, 1'b1, 20'h01006, "R5 filled free way");
    // Oldest now tag 3. R7: refill tag 1 in place, nothing evicted.
    do_cmd(2'd0, s7(1), 13'd1, 1'b0, 20'h0100F);
    do_lookup(s7(1), 13'd1, 1'b1, 20'h0100F, "R7 overwritten");
    do_lookup(s7(3), 13'd1, 1'b1, 20'h01003, "R7 no eviction");
    do_lookup(s7(5), 13'd1, 1'b1, 20'h01005, "R7 no eviction");
    do_lookup(s7(6), 13'd1, 1'b1, 20'h01006, "R7 no eviction");

    // R11: fill and lookup presented in the same cycle
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_vpn = 20'h0ABCD; cmd_ctx = 13'd2;
    cmd_global = 1'b0; cmd_ppn = 20'h5A5A7; cmd_prop = 4'h7;
    lk_valid = 1'b1; lk_vpn = 20'h0ABCD; lk_ctx = 13'd2;
    #1;
    chk(lk_ready == 1'b0, "R11 ready low under command", 32'(lk_ready), 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(rsp_valid == 1'b0, "R11 no response while stalled", 32'(rsp_valid), 0);
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rsp_valid && rsp_hit && rsp_ppn == 20'h5A5A7 && rsp_prop == 4'h7,
        "R11 held lookup sees fill", {7'd0, rsp_valid, rsp_hit, 3'd0, rsp_prop, rsp_ppn},
        {7'd0, 1'b1, 1'b1, 3'd0, 4'h7, 20'h5A5A7});
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R4 single-cycle response", 32'(rsp_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule